// File: doc/BRIEF.md
# JTAG to debug-module access bridge

This block is a JTAG test access port whose data-register scans are turned into transactions on a debug module interface. An external debugger selects an instruction through a 4-bit instruction register. It can then read a fixed identification word, load the debug-register address, read a 64-bit debug word, or write a new debug word. A write scan returns the word that was in that register before the write.

The TAP pins TCK, TMS and TDI are treated as slow signals. They are synchronised into the system clock domain. Edges of TCK are found there, so the whole block runs on one clock.

On the debug side the block holds a request, together with write-enable, address and write data, until the target returns a one-cycle acknowledge. Read data is taken with that acknowledge. The read for a read scan or a write scan is issued when the TAP enters Capture-DR. The write is issued when the TAP enters Update-DR.

Top module: `jtag_dmi_bridge`

## Requirements
- R1: After reset the instruction register selects the 32-bit identification register. A DR scan of that register shifts out 0x000018FF, least-significant bit first.
- R2: Five consecutive TCK rising edges sampled with TMS high bring the TAP to Test-Logic-Reset from any state. This holds even while a debug transaction holds the TAP in Capture-DR. Test-Logic-Reset selects the identification instruction (code 1).
- R3: The instruction register is 4 bits wide. An IR scan shifts out the capture pattern 0b0001, least-significant bit first. The instruction shifted in takes effect on entry to Update-IR.
- R4: Code 5 selects an 8-bit address register. Its scan shifts out the address currently held, and the address shifted in is loaded on entry to Update-DR.
- R5: Code 6 selects a 64-bit register. Entering Capture-DR issues a debug read (write-enable 0) at the held address. The same scan shifts out the word returned with the acknowledge.
- R6: Code 7 reads the addressed word at Capture-DR, and that scan shifts out this old value. On entry to Update-DR the word shifted in is written (write-enable 1) to the same address.
- R7: The request stays high with write-enable, address and write data unchanged until acknowledge is seen. It falls in the cycle after the acknowledge. Out of reset it is low.
- R8: Any instruction code other than 1, 5, 6 and 7 selects a 1-bit bypass register that captures 0. TDO then shows TDI delayed by one TCK cycle.
- R9: Entering Test-Logic-Reset drops a debug request that is still waiting for its acknowledge, and discards any transaction that has not yet been issued.
- R10: While a read for codes 6 or 7 is still outstanding, TCK rising edges that would leave Capture-DR are ignored. Shifting starts only after the read data is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tck_i | input | 1 | Test clock, sampled by clk |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Test data in |
| tdo_o | output | 1 | Test data out, changes after TCK falling edges |
| dmi_req_o | output | 1 | Debug transaction request |
| dmi_we_o | output | 1 | 1 for write, 0 for read |
| dmi_addr_o | output | ADDR_W | Debug register address |
| dmi_wdata_o | output | DATA_W | Write data |
| dmi_rdata_i | input | DATA_W | Read data, valid with acknowledge |
| dmi_ack_i | input | 1 | One-cycle acknowledge from the target |

## Verification
The bench builds the block with its default parameters: 4-bit instructions, an 8-bit address, 64-bit debug words, two synchroniser stages and a five-edge reset run. With these values the full 64-bit scan path, the old-value return of a write scan and the bypass path can all be observed within a few thousand TCK edges. The bench's target model adds a programmable acknowledge delay. A long delay makes the hold-off in Capture-DR visible, and withholding the acknowledge exposes the abort on Test-Logic-Reset.

// File: rtl/jdb_pkg.sv
// Shared types for the JTAG-to-debug bridge: TAP state encoding and the
// next-state function. Assumes the standard 16-state TAP graph.
package jdb_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
    } tap_state_e;

    // Next TAP state for one TCK rising edge with the given TMS value.
    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        case (s)
            TS_RESET:    tap_next = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     tap_next = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   tap_next = tms ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   tap_next = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: tap_next = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: tap_next = tms ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: tap_next = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: tap_next = tms ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   tap_next = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   tap_next = tms ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   tap_next = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: tap_next = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: tap_next = tms ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: tap_next = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: tap_next = tms ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   tap_next = tms ? TS_SEL_DR   : TS_IDLE;
            default:     tap_next = TS_RESET;
        endcase
    endfunction

endpackage

// File: rtl/jdb_pin_sync.sv
// Brings TCK, TMS and TDI into the clk domain through STAGES flops each,
// and flags TCK rising and falling edges. All three pins pass the same
// number of stages, so TMS/TDI line up with the detected edge.
// Assumes STAGES >= 2 and TCK much slower than clk.
module jdb_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tck,
    input  logic tms,
    input  logic tdi,
    output logic rise,
    output logic fall,
    output logic tms_s,
    output logic tdi_s
);
    logic [STAGES-1:0] tck_q, tms_q, tdi_q;
    logic              tck_d;

    // Synchroniser chains plus one delayed TCK copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tck_q <= '0;
            tms_q <= '0;
            tdi_q <= '0;
            tck_d <= 1'b0;
        end else begin
            tck_q <= {tck_q[STAGES-2:0], tck};
            tms_q <= {tms_q[STAGES-2:0], tms};
            tdi_q <= {tdi_q[STAGES-2:0], tdi};
            tck_d <= tck_q[STAGES-1];
        end
    end

    assign rise  = tck_q[STAGES-1] & ~tck_d;
    assign fall  = ~tck_q[STAGES-1] & tck_d;
    assign tms_s = tms_q[STAGES-1];
    assign tdi_s = tdi_q[STAGES-1];
endmodule

// File: rtl/jdb_tap_fsm.sv
// TAP controller. Advances on 'step' (a TCK rise that is not held off).
// Independently counts TCK rises with TMS high. RESET_RUN of them in a row
// force Test-Logic-Reset even if the steps were held off.
module jdb_tap_fsm
    import jdb_pkg::*;
#(
    parameter int RESET_RUN = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    input  logic       step,
    input  logic       tms,
    output tap_state_e state
);
    localparam int CW = $clog2(RESET_RUN + 1);
    localparam logic [CW-1:0] LAST = CW'(RESET_RUN - 1);

    logic [CW-1:0] hi_cnt;
    logic          force_rst;

    assign force_rst = rise && tms && (hi_cnt == LAST);

    // Count consecutive TMS-high rises, saturating at the last step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (rise)
            hi_cnt <= !tms ? '0 : (hi_cnt == LAST ? hi_cnt : hi_cnt + 1'b1);
    end

    // TAP state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= TS_RESET;
        else if (force_rst)
            state <= TS_RESET;
        else if (step)
            state <= tap_next(state, tms);
    end
endmodule

// File: rtl/jdb_dmi_seq.sv
// Debug-side handshake sequencer. Takes one read or write start at a time
// while idle. Latches command, address and data, and holds the request until
// acknowledge. Read data is kept in rd_hold. 'abort' drops the request.
// Assumes starts are only given while busy is low.
module jdb_dmi_seq #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    input  logic [DATA_W-1:0] rdata,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              busy,
    output logic [DATA_W-1:0] rd_hold
);
    // Request/command registers and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req     <= 1'b0;
            we      <= 1'b0;
            addr_o  <= '0;
            wdata_o <= '0;
            rd_hold <= '0;
        end else if (abort) begin
            req <= 1'b0;
        end else if (req) begin
            if (ack) begin
                req <= 1'b0;
                if (!we) rd_hold <= rdata;
            end
        end else if (start_wr) begin
            req     <= 1'b1;
            we      <= 1'b1;
            addr_o  <= addr;
            wdata_o <= wdata;
        end else if (start_rd) begin
            req    <= 1'b1;
            we     <= 1'b0;
            addr_o <= addr;
        end
    end

    assign busy = req;
endmodule

// File: rtl/jtag_dmi_bridge.sv
// JTAG TAP whose data-register scans drive debug-module transactions.
// Instructions: identification, debug address, debug read, debug write with
// old-value return. Any other code selects bypass. Everything runs in clk.
// TCK must be slow enough that each half period spans several clk cycles.
module jtag_dmi_bridge
    import jdb_pkg::*;
#(
    parameter int              IR_W        = 4,
    parameter int              ADDR_W      = 8,
    parameter int              DATA_W      = 64,
    parameter int              ID_W        = 32,
    parameter logic [ID_W-1:0] ID_VALUE    = 32'h0000_18FF,
    parameter int              SYNC_STAGES = 2,
    parameter int              RESET_RUN   = 5,
    parameter logic [IR_W-1:0] OP_ID       = 4'd1,
    parameter logic [IR_W-1:0] OP_ADDR     = 4'd5,
    parameter logic [IR_W-1:0] OP_READ     = 4'd6,
    parameter logic [IR_W-1:0] OP_WRRD     = 4'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tck_i,
    input  logic              tms_i,
    input  logic              tdi_i,
    output logic              tdo_o,
    output logic              dmi_req_o,
    output logic              dmi_we_o,
    output logic [ADDR_W-1:0] dmi_addr_o,
    output logic [DATA_W-1:0] dmi_wdata_o,
    input  logic [DATA_W-1:0] dmi_rdata_i,
    input  logic              dmi_ack_i
);
    localparam int LEN_W = $clog2(DATA_W + 1);

    logic              tck_rise, tck_fall, tms_s, tdi_s;
    tap_state_e        state, nxt;
    logic              step, freeze, tap_rst, sel_dmi;
    logic [IR_W-1:0]   ir_q, ir_sr;
    logic [DATA_W-1:0] dr_sr, dr_shifted, cap_val, wr_buf, rd_hold;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  dr_len;
    logic              rd_pend, wr_pend, start_rd, start_wr, seq_busy;

    jdb_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tck(tck_i), .tms(tms_i), .tdi(tdi_i),
        .rise(tck_rise), .fall(tck_fall), .tms_s(tms_s), .tdi_s(tdi_s)
    );

    jdb_tap_fsm #(.RESET_RUN(RESET_RUN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rise(tck_rise), .step(step), .tms(tms_s),
        .state(state)
    );

    jdb_dmi_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .abort(tap_rst),
        .start_rd(start_rd), .start_wr(start_wr),
        .addr(addr_q), .wdata(wr_buf),
        .ack(dmi_ack_i), .rdata(dmi_rdata_i),
        .req(dmi_req_o), .we(dmi_we_o), .addr_o(dmi_addr_o), .wdata_o(dmi_wdata_o),
        .busy(seq_busy), .rd_hold(rd_hold)
    );

    // Decode the active instruction: DR length and debug-path selection.
    always_comb begin
        sel_dmi = (ir_q == OP_READ) || (ir_q == OP_WRRD);
        if (ir_q == OP_ID)
            dr_len = LEN_W'(ID_W);
        else if (ir_q == OP_ADDR)
            dr_len = LEN_W'(ADDR_W);
        else if (sel_dmi)
            dr_len = LEN_W'(DATA_W);
        else
            dr_len = LEN_W'(1);
    end

    // Capture value of the selected data register.
    always_comb begin
        if (ir_q == OP_ID)
            cap_val = DATA_W'(ID_VALUE);
        else if (ir_q == OP_ADDR)
            cap_val = DATA_W'(addr_q);
        else if (sel_dmi)
            cap_val = rd_hold;
        else
            cap_val = '0;
    end

    // One shift step: right shift, TDI enters at the top of the selected length.
    always_comb begin
        dr_shifted = dr_sr >> 1;
        for (int i = 0; i < DATA_W; i++) begin
            if (i == int'(dr_len) - 1) dr_shifted[i] = tdi_s;
        end
    end

    // Step control: hold in Capture-DR while the debug read is outstanding.
    assign nxt      = tap_next(state, tms_s);
    assign tap_rst  = (state == TS_RESET);
    assign freeze   = (state == TS_CAP_DR) && sel_dmi && (rd_pend || seq_busy);
    assign step     = tck_rise && !freeze;
    assign start_wr = wr_pend && !seq_busy && !tap_rst;
    assign start_rd = rd_pend && !wr_pend && !seq_busy && !tap_rst;

    // Instruction, shift and address registers plus transaction bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q    <= OP_ID;
            ir_sr   <= '0;
            dr_sr   <= '0;
            addr_q  <= '0;
            wr_buf  <= '0;
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
        end else if (tap_rst) begin
            ir_q    <= OP_ID;
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            if (start_rd) rd_pend <= 1'b0;
            if (start_wr) wr_pend <= 1'b0;
            if (step) begin
                case (state)
                    TS_CAP_DR:   dr_sr <= cap_val;
                    TS_SHIFT_DR: dr_sr <= dr_shifted;
                    TS_CAP_IR:   ir_sr <= IR_W'(1);
                    TS_SHIFT_IR: ir_sr <= {tdi_s, ir_sr[IR_W-1:1]};
                    default: ;
                endcase
                if (nxt == TS_UPD_IR)
                    ir_q <= ir_sr;
                if (nxt == TS_UPD_DR && ir_q == OP_ADDR)
                    addr_q <= dr_sr[ADDR_W-1:0];
                if (nxt == TS_UPD_DR && ir_q == OP_WRRD) begin
                    wr_pend <= 1'b1;
                    wr_buf  <= dr_sr;
                end
                if (nxt == TS_CAP_DR && sel_dmi)
                    rd_pend <= 1'b1;
            end
        end
    end

    // TDO changes after TCK falls, showing the LSB of the shifting register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tdo_o <= 1'b0;
        else if (tck_fall) begin
            if (state == TS_SHIFT_DR)
                tdo_o <= dr_sr[0];
            else if (state == TS_SHIFT_IR)
                tdo_o <= ir_sr[0];
        end
    end
endmodule

// File: rtl/jdb_bridge_chk.sv
// Protocol checker for the debug-side handshake of jtag_dmi_bridge,
// attached by bind. tap_rst is the bridge's Test-Logic-Reset indication.
module jdb_bridge_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tap_rst,
    input logic              dmi_req_o,
    input logic              dmi_we_o,
    input logic [ADDR_W-1:0] dmi_addr_o,
    input logic [DATA_W-1:0] dmi_wdata_o,
    input logic              dmi_ack_i
);
    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmi_req_o && !dmi_ack_i && !tap_rst) |=> dmi_req_o);

    // R7
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmi_req_o && dmi_ack_i) |=> !dmi_req_o);

    // R7
    cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmi_req_o && !dmi_ack_i && !tap_rst) |=>
            ($stable(dmi_we_o) && $stable(dmi_addr_o) && $stable(dmi_wdata_o)));

    // R9
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_rst |=> !dmi_req_o);
endmodule

bind jtag_dmi_bridge jdb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tap_rst(tap_rst),
    .dmi_req_o(dmi_req_o), .dmi_we_o(dmi_we_o), .dmi_addr_o(dmi_addr_o),
    .dmi_wdata_o(dmi_wdata_o), .dmi_ack_i(dmi_ack_i)
);

// File: tb/sim_jtag_dmi_bridge.sv
module sim_jtag_dmi_bridge;
    localparam int H = 8;   // clk cycles per TCK half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tck = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic        tdo, req, we, ack = 1'b0;
    logic [7:0]  addr;
    logic [63:0] wdata, rdata = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // target model state
    logic [63:0] mem [256];
    bit          ack_en = 1;
    int          ack_dly = 2;
    int          wait_cnt = 0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [7:0]  last_waddr = '0;
    logic [63:0] last_wdata = '0;

    always #5 clk = ~clk;

    jtag_dmi_bridge u0 (
        .clk(clk), .rst_n(rst_n), .tck_i(tck), .tms_i(tms), .tdi_i(tdi),
        .tdo_o(tdo), .dmi_req_o(req), .dmi_we_o(we), .dmi_addr_o(addr),
        .dmi_wdata_o(wdata), .dmi_rdata_i(rdata), .dmi_ack_i(ack)
    );

    // Target: acknowledges each request after ack_dly waiting cycles.
    always @(posedge clk) begin
        ack <= 1'b0;
        if (!ack_en || !req || ack) begin
            wait_cnt <= 0;
        end else if (wait_cnt >= ack_dly) begin
            ack <= 1'b1;
            wait_cnt <= 0;
            if (we) begin
                mem[addr] <= wdata;
                wr_cnt <= wr_cnt + 1;
                last_waddr <= addr;
                last_wdata <= wdata;
            end else begin
                rdata <= mem[addr];
                rd_cnt <= rd_cnt + 1;
            end
        end else begin
            wait_cnt <= wait_cnt + 1;
        end
    end

    typedef struct packed {
        logic [3:0]  ir;
        logic [6:0]  len;
        logic [63:0] din;
        logic [63:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'd1, 7'd32, 64'h0,                   64'h0000_0000_0000_18FF},
        '{4'd5, 7'd8,  64'h11,                  64'h0},
        '{4'd5, 7'd8,  64'h11,                  64'h11},
        '{4'd6, 7'd64, 64'h0,                   64'h1234_5678_0000_0033},
        '{4'd7, 7'd64, 64'hFEED_FACE_0BAD_F00D, 64'h1234_5678_0000_0033},
        '{4'd6, 7'd64, 64'h0,                   64'hFEED_FACE_0BAD_F00D},
        '{4'd5, 7'd8,  64'h2C,                  64'h11},
        '{4'd6, 7'd64, 64'h0,                   64'h1234_5678_0000_0084}
    };

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tck_cycle(input logic t_ms, input logic t_di, output logic t_do);
        tms = t_ms;
        tdi = t_di;
        repeat (H) @(negedge clk);
        t_do = tdo;
        tck = 1'b1;
        repeat (H) @(negedge clk);
        tck = 1'b0;
    endtask

    task automatic ir_scan(input logic [3:0] code, output logic [3:0] cap);
        logic b;
        tck_cycle(1, 0, b); tck_cycle(1, 0, b); tck_cycle(0, 0, b); tck_cycle(0, 0, b);
        for (int i = 0; i < 4; i++) begin
            tck_cycle(i == 3, code[i], b);
            cap[i] = b;
        end
        tck_cycle(1, 0, b); tck_cycle(0, 0, b);
    endtask

    // DR scan from Run-Test/Idle; 'drop' tries an early exit from Capture-DR.
    task automatic dr_scan(input int len, input logic [63:0] din,
                           output logic [63:0] dout, input bit drop);
        logic b;
        dout = '0;
        tck_cycle(1, 0, b); tck_cycle(0, 0, b);
        if (drop) begin
            tck_cycle(1, 0, b);
            repeat (200) @(negedge clk);
        end
        tck_cycle(0, 0, b);
        for (int i = 0; i < len; i++) begin
            tck_cycle(i == len - 1, din[i], b);
            dout[i] = b;
        end
        tck_cycle(1, 0, b); tck_cycle(0, 0, b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            report();
        end
    end

    initial begin
        logic [3:0]  cap;
        logic [63:0] res;
        logic        b;
        for (int a = 0; a < 256; a++) mem[a] = 64'h1234_5678_0000_0000 | 64'(a * 3);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state of the outputs (R7)
        chk("R7 reset req", 64'(req), 64'h0);
        chk("R7 reset addr", 64'(addr), 64'h0);
        chk("R1 reset tdo", 64'(tdo), 64'h0);

        tck_cycle(0, 0, b);   // Test-Logic-Reset -> Run-Test/Idle

        // R1 identification straight out of reset, no IR scan
        dr_scan(32, 64'h0, res, 0);
        chk("R1 idcode after reset", res, 64'h18FF);

        // R3 capture pattern of the instruction register
        ir_scan(4'd1, cap);
        chk("R3 ir capture", 64'(cap), 64'h1);

        // vector walk: R1, R4, R5, R6
        for (int v = 0; v < 8; v++) begin
            string tag;
            case (VECS[v].ir)
                4'd1:    tag = "R1 vector";
                4'd5:    tag = "R4 vector";
                4'd6:    tag = "R5 vector";
                default: tag = "R6 vector";
            endcase
            ir_scan(VECS[v].ir, cap);
            dr_scan(int'(VECS[v].len), VECS[v].din, res, 0);
            chk(tag, res, VECS[v].exp);
        end

        // R6 one write, to the held address, with the shifted-in word
        chk("R6 write count", 64'(wr_cnt), 64'd1);
        chk("R6 write addr", 64'(last_waddr), 64'h11);
        chk("R6 write data", last_wdata, 64'hFEED_FACE_0BAD_F00D);
        // R5 reads only for codes 6 and 7 scans
        chk("R5 read count", 64'(rd_cnt), 64'd4);

        // R8 bypass with undecoded codes
        ir_scan(4'd3, cap);
        dr_scan(8, 64'hA5, res, 0);
        chk("R8 bypass code 3", res, 64'h4A);
        ir_scan(4'd15, cap);
        dr_scan(2, 64'h1, res, 0);
        chk("R8 bypass code 15", res, 64'h2);
        chk("R8 no debug traffic", 64'(rd_cnt + wr_cnt), 64'd5);

        // R10 early exit from Capture-DR is ignored while the read is slow
        ack_dly = 80;
        ir_scan(4'd6, cap);
        dr_scan(64, 64'h0, res, 1);
        chk("R10 held capture", res, 64'h1234_5678_0000_0084);
        ack_dly = 2;

        // R9 / R2 withheld acknowledge, then five TMS-high edges
        ack_en = 0;
        tck_cycle(1, 0, b); tck_cycle(0, 0, b);     // into Capture-DR
        repeat (10) @(negedge clk);
        chk("R9 request pending", 64'(req), 64'h1);
        for (int k = 0; k < 5; k++) tck_cycle(1, 0, b);
        repeat (4) @(negedge clk);
        chk("R9 request dropped", 64'(req), 64'h0);
        ack_en = 1;
        tck_cycle(0, 0, b);
        dr_scan(32, 64'h0, res, 0);
        chk("R2 reset selects idcode", res, 64'h18FF);
        chk("R9 no extra read", 64'(rd_cnt), 64'd5);

        // R2 from Shift-IR, mid-instruction
        tck_cycle(1, 0, b); tck_cycle(1, 0, b); tck_cycle(0, 0, b); tck_cycle(0, 0, b);
        tck_cycle(0, 0, b); tck_cycle(0, 1, b);
        for (int k = 0; k < 5; k++) tck_cycle(1, 0, b);
        tck_cycle(0, 0, b);
        dr_scan(32, 64'h0, res, 0);
        chk("R2 reset from shift-ir", res, 64'h18FF);

        done = 1;
        report();
    end
endmodule